// File: doc/BRIEF.md
# Dual-Host Sound Interrupt Controller

This block gathers interrupt requests from the sources of a sound subsystem and delivers them to two processors. Each processor has its own bank of three registers: an enable mask, a pending set and a write-one-to-clear port. Eleven source positions exist per bank. Hardware sources arrive as one-cycle pulses on `hw_src` and set the matching pending bit in both banks. The sample tick sets only the sample-done bit of the slave bank. Software can raise its own interrupt by writing a one to the software bit of a pending register. Every other bit of a pending register ignores writes.

The slave audio processor receives a request line and a 3-bit level code. The code belongs to the lowest-numbered source that is both pending and enabled. Each level bit is taken from one of three 8-bit level registers, indexed by source position. Sources above position 7 share position 7. The main host processor receives one level-sensitive line, driven by a two-state machine. In `LINE_IDLE` the transition RAISE (any enabled pending main source) moves it to `LINE_HIGH`. In `LINE_HIGH` the transition DROP (no enabled pending main source) returns it to `LINE_IDLE`. The line is high exactly in `LINE_HIGH`, so it cannot be raised a second time while it is already up.

Top module: `dual_irq_ctrl`

## Requirements
- R1: A slave source is active when its pending and enable bits are both 1. `slv_irq` is 1 when any slave source is active. Enable registers are read/write in bits [10:0], and unused bits read 0.
- R2: A pulse on `hw_src[i]` sets pending bit i in both the slave and the main bank.
- R3: When several slave sources are active, the lowest bit index decides `slv_lvl`.
- R4: For winning source i, `slv_lvl[k]` equals bit i of level register k. The level registers are at 0x28A8 (k=0), 0x28AC (k=1) and 0x28B0 (k=2), each 8 bits wide.
- R5: A winning source with index above 7 uses bit 7 of the level registers.
- R6: A write to a pending register (slave 0x28A0, main 0x28B8) changes nothing, except that a 1 in data bit 5 sets pending bit 5.
- R7: A write to a clear register (slave 0x28A4, main 0x28BC) clears each pending bit whose data bit is 1, whatever the enable bits hold. Reads of a clear register return 0.
- R8: `sample_tick` sets slave pending bit 10 and leaves the main bank unchanged.
- R9: `host_irq` is 1 while any main source is active (main enable at 0x28B4) and returns to 0 once none is active.
- R10: A hardware set and a clear write hitting the same pending bit in the same cycle leave the bit set.
- R11: `slv_lvl` is 0 whenever `slv_irq` is 0.
- R12: Outputs are registered. A pending or enable change made at clock edge N shows on the outputs after edge N+1.
- R13: Synchronous active-high `rst` clears all enable, pending and level registers and drives all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| hw_src | input | 11 | One-cycle hardware source pulses |
| sample_tick | input | 1 | Sample-done pulse (slave bit 10) |
| slv_irq | output | 1 | Slave processor request |
| slv_lvl | output | 3 | Slave processor level code |
| host_irq | output | 1 | Main host request line |

## Verification
The bench targets priority among several active sources. A design that scanned from the top would report the level of source 3 instead of source 1. It checks the alias of sources 9 and 10 onto level position 7: indexing past the 8-bit level registers would yield 0 instead of 3. It writes pending registers with every bit except bit 5 set, to catch a design that accepts software writes to pending. It also clears a bit whose enable is 0, to catch a design that masks clears with the enable. Finally, it sends a set and a clear to the same bit in one cycle; a design that lets the clear win would drop `host_irq`.

// File: rtl/sic_pkg.sv
package sic_pkg;
    localparam int NSRC_DEF  = 11;
    localparam int SW_BIT    = 5;
    localparam int TICK_BIT  = 10;
    localparam int LVL_W_DEF = 8;
    localparam int LVL_CODE  = 3;

    typedef enum logic {
        LINE_IDLE = 1'b0,
        LINE_HIGH = 1'b1
    } line_st_e;
endpackage

// File: rtl/sic_bank.sv
module sic_bank #(
    parameter int NSRC = 11,
    parameter int SWB  = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] set_hw,
    input  logic            en_we,
    input  logic            pd_we,
    input  logic            clr_we,
    input  logic [NSRC-1:0] wdata,
    output logic [NSRC-1:0] en_q,
    output logic [NSRC-1:0] pd_q,
    output logic [NSRC-1:0] act
);
    localparam logic [NSRC-1:0] SW_MASK = {{(NSRC-1){1'b0}}, 1'b1} << SWB;

    logic [NSRC-1:0] sw_set, set_all, clr_mask, pd_d;
    logic            past_ok;

    always_comb begin
        sw_set   = (pd_we && wdata[SWB]) ? SW_MASK : '0;
        set_all  = set_hw | sw_set;
        clr_mask = clr_we ? wdata : '0;
        pd_d     = (pd_q & ~clr_mask) | set_all;
        act      = pd_q & en_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= '0;
            pd_q    <= '0;
            past_ok <= 1'b0;
        end else begin
            if (en_we) en_q <= wdata;
            pd_q    <= pd_d;
            past_ok <= 1'b1;
        end
    end

    assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> ((pd_q & $past(set_hw)) == $past(set_hw)));

    assert_clear_applies_R7: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(clr_we)) |->
            ((pd_q & $past(wdata) & ~$past(set_hw)) == '0));

    assert_pend_ro_R6: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(pd_we) && $past(set_hw) == '0) |->
            ((pd_q & ~SW_MASK) == ($past(pd_q) & ~SW_MASK)));
endmodule

// File: rtl/sic_prio_level.sv
module sic_prio_level #(
    parameter int NSRC  = 11,
    parameter int LVL_W = 8
) (
    input  logic [NSRC-1:0]  act,
    input  logic [LVL_W-1:0] lv0,
    input  logic [LVL_W-1:0] lv1,
    input  logic [LVL_W-1:0] lv2,
    output logic             any,
    output logic [2:0]       lvl
);
    logic [2:0] src_lvl [NSRC];

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        localparam int P = (g > LVL_W - 1) ? LVL_W - 1 : g;
        assign src_lvl[g] = {lv2[P], lv1[P], lv0[P]};
    end

    always_comb begin
        any = |act;
        lvl = 3'd0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (act[i]) lvl = src_lvl[i];
        end
    end
endmodule

// File: rtl/sic_host_line.sv
module sic_host_line
    import sic_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic any,
    output logic line
);
    line_st_e st, st_n;

    always_ff @(posedge clk) begin
        if (rst) st <= LINE_IDLE;
        else     st <= st_n;
    end

    always_comb begin
        st_n = st;
        unique case (st)
            LINE_IDLE: if (any)  st_n = LINE_HIGH;
            LINE_HIGH: if (!any) st_n = LINE_IDLE;
        endcase
    end

    always_comb line = (st == LINE_HIGH);

    assert_raise_R9: assert property (@(posedge clk) disable iff (rst)
        any |=> line);
    assert_drop_R9: assert property (@(posedge clk) disable iff (rst)
        !any |=> !line);
endmodule

// File: rtl/dual_irq_ctrl.sv
module dual_irq_ctrl
    import sic_pkg::*;
#(
    parameter int                NSRC     = NSRC_DEF,
    parameter int                LVL_W    = LVL_W_DEF,
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] S_BASE   = 'h289C,
    parameter logic [ADDR_W-1:0] M_BASE   = 'h28B4,
    parameter logic [ADDR_W-1:0] LVL_BASE = 'h28A8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NSRC-1:0]   hw_src,
    input  logic              sample_tick,
    output logic              slv_irq,
    output logic [2:0]        slv_lvl,
    output logic              host_irq
);
    localparam logic [ADDR_W-1:0] S_EN  = S_BASE;
    localparam logic [ADDR_W-1:0] S_PD  = S_BASE + ADDR_W'(4);
    localparam logic [ADDR_W-1:0] S_CLR = S_BASE + ADDR_W'(8);
    localparam logic [ADDR_W-1:0] M_EN  = M_BASE;
    localparam logic [ADDR_W-1:0] M_PD  = M_BASE + ADDR_W'(4);
    localparam logic [ADDR_W-1:0] M_CLR = M_BASE + ADDR_W'(8);
    localparam logic [ADDR_W-1:0] L0_A  = LVL_BASE;
    localparam logic [ADDR_W-1:0] L1_A  = LVL_BASE + ADDR_W'(4);
    localparam logic [ADDR_W-1:0] L2_A  = LVL_BASE + ADDR_W'(8);
    localparam logic [NSRC-1:0]   TICK_MASK = {{(NSRC-1){1'b0}}, 1'b1} << TICK_BIT;

    logic [NSRC-1:0]  s_en, s_pd, s_act, m_en, m_pd, m_act, s_set;
    logic [LVL_W-1:0] lvl_q [3];
    logic             s_any, m_any, past_ok;
    logic [2:0]       s_lvl_c;
    logic             unused_wdata;

    assign unused_wdata = ^bus_wdata[31:NSRC];
    assign s_set = hw_src | (sample_tick ? TICK_MASK : '0);

    sic_bank #(.NSRC(NSRC), .SWB(SW_BIT)) u_slave_bank (
        .clk(clk), .rst(rst), .set_hw(s_set),
        .en_we(bus_we && bus_addr == S_EN),
        .pd_we(bus_we && bus_addr == S_PD),
        .clr_we(bus_we && bus_addr == S_CLR),
        .wdata(bus_wdata[NSRC-1:0]),
        .en_q(s_en), .pd_q(s_pd), .act(s_act)
    );

    sic_bank #(.NSRC(NSRC), .SWB(SW_BIT)) u_main_bank (
        .clk(clk), .rst(rst), .set_hw(hw_src),
        .en_we(bus_we && bus_addr == M_EN),
        .pd_we(bus_we && bus_addr == M_PD),
        .clr_we(bus_we && bus_addr == M_CLR),
        .wdata(bus_wdata[NSRC-1:0]),
        .en_q(m_en), .pd_q(m_pd), .act(m_act)
    );

    sic_prio_level #(.NSRC(NSRC), .LVL_W(LVL_W)) u_pick (
        .act(s_act), .lv0(lvl_q[0]), .lv1(lvl_q[1]), .lv2(lvl_q[2]),
        .any(s_any), .lvl(s_lvl_c)
    );

    assign m_any = |m_act;

    sic_host_line u_host_line (
        .clk(clk), .rst(rst), .any(m_any), .line(host_irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < 3; k++) lvl_q[k] <= '0;
            slv_irq <= 1'b0;
            slv_lvl <= 3'd0;
            past_ok <= 1'b0;
        end else begin
            if (bus_we && bus_addr == L0_A) lvl_q[0] <= bus_wdata[LVL_W-1:0];
            if (bus_we && bus_addr == L1_A) lvl_q[1] <= bus_wdata[LVL_W-1:0];
            if (bus_we && bus_addr == L2_A) lvl_q[2] <= bus_wdata[LVL_W-1:0];
            slv_irq <= s_any;
            slv_lvl <= s_lvl_c;
            past_ok <= 1'b1;
        end
    end

    always_comb begin
        case (bus_addr)
            S_EN:    bus_rdata = 32'(s_en);
            S_PD:    bus_rdata = 32'(s_pd);
            M_EN:    bus_rdata = 32'(m_en);
            M_PD:    bus_rdata = 32'(m_pd);
            L0_A:    bus_rdata = 32'(lvl_q[0]);
            L1_A:    bus_rdata = 32'(lvl_q[1]);
            L2_A:    bus_rdata = 32'(lvl_q[2]);
            default: bus_rdata = 32'd0;
        endcase
    end

    assert_lvl_zero_R11: assert property (@(posedge clk) disable iff (rst)
        !slv_irq |-> (slv_lvl == 3'd0));
    assert_out_reg_R12: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> (slv_irq == $past(|(s_pd & s_en))));
    assert_tick_sets_R8: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(sample_tick)) |-> s_pd[TICK_BIT]);
endmodule

// File: tb/dual_irq_ctrl_bench.sv
module dual_irq_ctrl_bench;
    localparam logic [15:0] SEN = 16'h289C, SPD = 16'h28A0, SCLR = 16'h28A4;
    localparam logic [15:0] LV0 = 16'h28A8, LV1 = 16'h28AC, LV2 = 16'h28B0;
    localparam logic [15:0] MEN = 16'h28B4, MPD = 16'h28B8, MCLR = 16'h28BC;

    logic        clk = 1'b0, rst = 1'b1, bus_we = 1'b0, sample_tick = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [10:0] hw_src = '0;
    logic        slv_irq, host_irq;
    logic [2:0]  slv_lvl;

    int checks = 0, errors = 0;
    bit done = 0;

    logic        q_sirq[$], q_hirq[$], q_chk[$];
    logic [2:0]  q_lvl[$];
    logic [31:0] q_rd[$];
    string       q_tag[$];
    event        chk_ev;

    always #2 clk = ~clk;

    dual_irq_ctrl u_dual_irq_ctrl (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_src(hw_src),
        .sample_tick(sample_tick), .slv_irq(slv_irq), .slv_lvl(slv_lvl),
        .host_irq(host_irq)
    );

    // monitor: pops expected items and compares with the outputs
    initial begin
        forever begin
            @(chk_ev);
            while (q_tag.size() != 0) begin
                logic si, hi, ck;
                logic [2:0] lv;
                logic [31:0] rd;
                string tg;
                si = q_sirq.pop_front(); hi = q_hirq.pop_front();
                ck = q_chk.pop_front();  lv = q_lvl.pop_front();
                rd = q_rd.pop_front();   tg = q_tag.pop_front();
                checks++;
                if (slv_irq !== si || slv_lvl !== lv || host_irq !== hi ||
                    (ck && bus_rdata !== rd)) begin
                    errors++;
                    $display("FAIL %s: got irq=%0b lvl=%0d host=%0b rd=%h, expected irq=%0b lvl=%0d host=%0b rd=%h",
                             tg, slv_irq, slv_lvl, host_irq, bus_rdata, si, lv, hi, rd);
                end
            end
        end
    end

    task automatic expect_out(input logic si, input logic [2:0] lv, input logic hi, input string tg);
        q_sirq.push_back(si); q_lvl.push_back(lv); q_hirq.push_back(hi);
        q_chk.push_back(1'b0); q_rd.push_back('0); q_tag.push_back(tg);
        ->chk_ev;
        #0;
    endtask

    task automatic expect_rd(input logic [15:0] a, input logic [31:0] v, input logic si,
                             input logic [2:0] lv, input logic hi, input string tg);
        bus_addr = a;
        #1;
        q_sirq.push_back(si); q_lvl.push_back(lv); q_hirq.push_back(hi);
        q_chk.push_back(1'b1); q_rd.push_back(v); q_tag.push_back(tg);
        ->chk_ev;
        #0;
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse(input logic [10:0] m);
        @(negedge clk);
        hw_src = m;
        @(negedge clk);
        hw_src = '0;
        @(negedge clk);
    endtask

    task automatic tick();
        @(negedge clk);
        sample_tick = 1'b1;
        @(negedge clk);
        sample_tick = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        expect_rd(SEN, 0, 0, 0, 0, "R13 reset enable");
        expect_rd(SPD, 0, 0, 0, 0, "R13 reset pending");

        pulse(11'h008);
        expect_rd(SPD, 32'h8, 0, 0, 0, "R2 slave pending set, R1 not enabled");
        expect_rd(MPD, 32'h8, 0, 0, 0, "R2 main pending set");

        wr(LV0, 32'h88); wr(LV1, 32'h82); wr(LV2, 32'h08);
        wr(SEN, 32'h8);
        expect_out(1, 3'd5, 0, "R1 R4 level of source 3");

        pulse(11'h002);
        wr(SEN, 32'hA);
        expect_out(1, 3'd2, 0, "R3 lowest index wins");
        wr(SCLR, 32'h2);
        expect_out(1, 3'd5, 0, "R7 clear source 1");

        wr(SCLR, 32'h7FF); wr(SEN, 32'h200);
        expect_out(0, 3'd0, 0, "R11 level zero when idle");
        pulse(11'h200);
        expect_out(1, 3'd3, 0, "R5 source 9 aliases bit 7");

        wr(SPD, 32'h7DF);
        expect_rd(SPD, 32'h200, 1, 3'd3, 0, "R6 pending write ignored");
        wr(SPD, 32'h020);
        expect_rd(SPD, 32'h220, 1, 3'd3, 0, "R6 software bit sets");
        wr(SEN, 32'h220);
        expect_out(1, 3'd0, 0, "R3 software source 5 wins");
        expect_rd(SCLR, 32'h0, 1, 3'd0, 0, "R7 clear reads zero");

        wr(SEN, 32'h0);
        pulse(11'h010);
        wr(SCLR, 32'h10);
        expect_rd(SPD, 32'h220, 0, 3'd0, 0, "R7 clear without enable");

        tick();
        expect_rd(SPD, 32'h620, 0, 3'd0, 0, "R8 tick sets slave bit 10");
        expect_rd(MPD, 32'h21A, 0, 3'd0, 0, "R8 main untouched by tick");
        wr(SCLR, 32'h7FF); wr(SEN, 32'h400);
        tick();
        expect_out(1, 3'd3, 0, "R5 R8 tick source level");

        wr(MEN, 32'h4);
        @(negedge clk);
        hw_src = 11'h004;
        @(negedge clk);
        hw_src = '0;
        expect_out(1, 3'd3, 0, "R12 output lags one cycle");
        @(negedge clk);
        expect_out(1, 3'd3, 1, "R9 host raised");
        repeat (3) @(negedge clk);
        expect_out(1, 3'd3, 1, "R9 host held");

        bus_addr = MCLR; bus_wdata = 32'h4; bus_we = 1'b1; hw_src = 11'h004;
        @(negedge clk);
        bus_we = 1'b0; hw_src = '0;
        @(negedge clk);
        expect_rd(MPD, 32'h21E, 1, 3'd3, 1, "R10 set beats clear");

        wr(MCLR, 32'h4);
        expect_rd(MPD, 32'h21A, 1, 3'd3, 0, "R9 host dropped");
        wr(MPD, 32'h20); wr(MEN, 32'h20);
        expect_out(1, 3'd3, 1, "R6 main software bit");

        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        expect_rd(MEN, 0, 0, 3'd0, 0, "R13 reset clears main enable");
        expect_rd(LV0, 0, 0, 3'd0, 0, "R13 reset clears level");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule